// File: doc/BRIEF.md
# Precise Exception Retirement Controller

This block sits at the retire end of a reorder buffer in an out-of-order core. It sees only the oldest entry, the head: whether it is valid, whether it has finished, whether an execution unit flagged a fault on it, the fault class and the head's address. The core retires one instruction per cycle, strictly from the head. An exception is therefore acted on only when its instruction becomes the oldest. By then every older instruction has retired, and any fault those older instructions raised has already been taken. Faults that execution units detect out of order are handled in program order.

When an exception is taken, the block does four things:
- It pulses a flush that discards the faulting entry and everything younger in one cycle.
- It saves a restart address in save register 0 and the pre-entry machine state in save register 1.
- It enters supervisor mode with interrupts masked.
- It redirects fetch for one cycle to a fixed vector, `VEC_BASE + class * 2^VEC_SHIFT`, using 32-bit unsigned arithmetic with any carry dropped.

An external interrupt that is enabled first stops dispatch. It is taken only once the buffer is empty. System reset and machine check are taken at once from any state and overwrite both save registers. A return request restores the machine state and resumes at save register 0. A floating-point mode field is kept in the machine state, and a request for the imprecise-recoverable mode is stored as precise.

The state machine has five states:
- `ST_RUN`: normal retirement.
- `ST_DRAIN`: an interrupt is pending and the block is waiting for the buffer to empty.
- `ST_ENTER`: the one-cycle flush and redirect to the vector.
- `ST_HANDLER`: the handler is running with exceptions masked.
- `ST_RETURN`: the one-cycle flush and redirect to save register 0.

Transitions:
- RUN→ENTER on a faulting head, RUN→DRAIN on an enabled interrupt.
- DRAIN→ENTER on a faulting head or an empty buffer, DRAIN→RUN when the interrupt drops.
- ENTER→HANDLER.
- HANDLER→RETURN on a return request.
- RETURN→RUN.
- Any state→ENTER on a catastrophic request.

Top module: `exc_retire_ctrl`

## Requirements
- R1: `retire` is high in the same cycle exactly when all of the following hold: `head_valid`, `head_done` and not `head_exc`; the state is ST_RUN, ST_DRAIN or ST_HANDLER (in ST_HANDLER only without `rfi`); and neither `sreset` nor `mcheck` is high.
- R2: A head with `head_valid`, `head_done` and `head_exc` in ST_RUN or ST_DRAIN is not retired. The next cycle is ST_ENTER, with `save0` equal to that head's address and the vector computed from `head_cls`.
- R3: With `irq` high and the enable bit set in ST_RUN, the next state is ST_DRAIN, with `hold_dispatch` high only in ST_DRAIN. In ST_DRAIN, `rob_empty` leads to ST_ENTER with class 5, and a low `irq` leads back to ST_RUN. `irq` has no effect while the enable bit is clear.
- R4: The next sequential address is the last retired `head_pc + 4` modulo 2^32, or the last redirect target, whichever is more recent. Interrupt and catastrophic entries save it in `save0`.
- R5: On every entry, `save1` takes the machine state held before entry, `msr_sup` becomes 1 and `msr_ee` becomes 0. The machine state is packed as {fp_mode[1:0], ee, sup}, with sup at bit 0.
- R6: In ST_ENTER, `flush` and `redir_valid` are high and `retire` is low. `redir_pc` is `VEC_BASE + (class << VEC_SHIFT)` modulo 2^32. Without a new catastrophic request, `flush` lasts one cycle.
- R7: In ST_HANDLER, a faulting head is neither retired nor taken: it stalls until `rfi`. `irq` is ignored.
- R8: `rfi` in ST_HANDLER leads to ST_RETURN. In ST_RETURN, `flush` and `redir_valid` are high, `redir_pc` equals `save0`, and the machine state is restored from `save1`. ST_RUN follows. `rfi` has no effect in any other state.
- R9: `fpm_wr` stores `fpm_val` in `fp_mode` on the next edge, with encoding 00 off, 01 imprecise non-recoverable, 11 precise. The value 10 (imprecise recoverable) is stored as 11. The write is dropped in a cycle that enters or returns.
- R10: `sreset` (class 1) or `mcheck` (class 2) leads to ST_ENTER on the next edge from every state, whatever the enable bit. `sreset` wins if both are high, and the entry overwrites `save0` and `save1`.
- R11: After reset the state is ST_RUN, `msr_sup`=0, `msr_ee`=1, `fp_mode`=00, `save0`=0, `save1`=0, and `flush`, `redir_valid` and `hold_dispatch` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| head_valid | input | 1 | Reorder buffer head entry is valid |
| head_done | input | 1 | Head entry has completed execution |
| head_exc | input | 1 | Head entry carries an exception condition |
| head_cls | input | CLS_W | Exception class of the head entry |
| head_pc | input | AW | Address of the head instruction |
| rob_empty | input | 1 | Reorder buffer holds no entries |
| irq | input | 1 | External interrupt request |
| sreset | input | 1 | System reset exception request |
| mcheck | input | 1 | Machine check request |
| rfi | input | 1 | Return-from-exception request |
| fpm_wr | input | 1 | Floating-point mode write strobe |
| fpm_val | input | 2 | Floating-point mode value to write |
| retire | output | 1 | Head retires this cycle |
| flush | output | 1 | Invalidate all buffer entries this cycle |
| hold_dispatch | output | 1 | Stop dispatch while draining for an interrupt |
| redir_valid | output | 1 | Fetch redirect pulse |
| redir_pc | output | AW | Fetch redirect target |
| save0 | output | AW | Save register 0: restart address |
| save1 | output | 4 | Save register 1: saved machine state |
| msr_sup | output | 1 | Supervisor mode |
| msr_ee | output | 1 | Asynchronous exceptions enabled |
| fp_mode | output | 2 | Floating-point exception mode |

## Verification
Results arrive at three different delays:
- `retire` is combinational: it is due in the same cycle as the head inputs.
- A take, drain or return decision made at a rising edge shows up one cycle later as the registered state outputs: `flush`, `redir_valid`, `redir_pc` and `hold_dispatch`.
- `save0`, `save1`, the machine state and the floating-point mode likewise change at the edge that makes the decision.

The bench changes inputs one time unit after each rising edge. At each falling edge it compares every output against a behavioural model. The model first predicts from its current state and the present inputs, and only then advances as the next rising edge will. Catastrophic requests are applied in ST_HANDLER and ST_ENTER. Address and vector wrap-around is forced by retiring at the top of the address space and by using a vector base near the top.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_DRAIN,
        ST_ENTER,
        ST_HANDLER,
        ST_RETURN
    } exc_state_t;

    typedef struct packed {
        logic [1:0] fpm;
        logic       ee;
        logic       sup;
    } msr_t;

    localparam int CLS_SRESET = 1;
    localparam int CLS_MCHECK = 2;
    localparam int CLS_EXTIRQ = 5;

    localparam logic [1:0] FPM_OFF     = 2'b00;
    localparam logic [1:0] FPM_IMP_NR  = 2'b01;
    localparam logic [1:0] FPM_IMP_REC = 2'b10;
    localparam logic [1:0] FPM_PRECISE = 2'b11;

    // Recoverable imprecise mode is handled as precise mode.
    function automatic logic [1:0] fpm_fold(input logic [1:0] req);
        return (req == FPM_IMP_REC) ? FPM_PRECISE : req;
    endfunction

endpackage

// File: rtl/exc_fsm.sv
module exc_fsm
    import exc_pkg::*;
#(
    parameter int CLS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_valid,
    input  logic             head_done,
    input  logic             head_exc,
    input  logic [CLS_W-1:0] head_cls,
    input  logic             rob_empty,
    input  logic             irq,
    input  logic             irq_en,
    input  logic             sreset,
    input  logic             mcheck,
    input  logic             rfi,
    output exc_state_t       state_q,
    output logic             take,
    output logic             take_sync,
    output logic [CLS_W-1:0] take_cls,
    output logic             ret_go,
    output logic             retire,
    output logic             flush,
    output logic             redir_valid,
    output logic             hold_dispatch
);

    exc_state_t       state_d;
    logic             cat_req;
    logic [CLS_W-1:0] cat_cls;
    logic             head_ok;
    logic             head_bad;
    logic             irq_live;

    assign cat_req  = sreset | mcheck;
    assign cat_cls  = sreset ? CLS_W'(CLS_SRESET) : CLS_W'(CLS_MCHECK);
    assign head_ok  = head_valid & head_done & ~head_exc;
    assign head_bad = head_valid & head_done & head_exc;
    assign irq_live = irq & irq_en;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and entry events
    always_comb begin
        state_d   = state_q;
        take      = 1'b0;
        take_sync = 1'b0;
        take_cls  = '0;
        ret_go    = 1'b0;
        if (cat_req) begin
            state_d  = ST_ENTER;
            take     = 1'b1;
            take_cls = cat_cls;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (head_bad) begin
                        state_d   = ST_ENTER;
                        take      = 1'b1;
                        take_sync = 1'b1;
                        take_cls  = head_cls;
                    end else if (irq_live) begin
                        state_d = ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (head_bad) begin
                        state_d   = ST_ENTER;
                        take      = 1'b1;
                        take_sync = 1'b1;
                        take_cls  = head_cls;
                    end else if (!irq_live) begin
                        state_d = ST_RUN;
                    end else if (rob_empty) begin
                        state_d  = ST_ENTER;
                        take     = 1'b1;
                        take_cls = CLS_W'(CLS_EXTIRQ);
                    end
                end
                ST_ENTER: begin
                    state_d = ST_HANDLER;
                end
                ST_HANDLER: begin
                    if (rfi) begin
                        state_d = ST_RETURN;
                        ret_go  = 1'b1;
                    end
                end
                ST_RETURN: begin
                    state_d = ST_RUN;
                end
                default: begin
                    state_d = ST_RUN;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        retire        = 1'b0;
        flush         = 1'b0;
        redir_valid   = 1'b0;
        hold_dispatch = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                retire = head_ok & ~cat_req;
            end
            ST_DRAIN: begin
                retire        = head_ok & ~cat_req;
                hold_dispatch = 1'b1;
            end
            ST_ENTER, ST_RETURN: begin
                flush       = 1'b1;
                redir_valid = 1'b1;
            end
            ST_HANDLER: begin
                retire = head_ok & ~cat_req & ~rfi;
            end
            default: begin
                retire = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/exc_vector.sv
module exc_vector #(
    parameter int              AW        = 32,
    parameter int              CLS_W     = 3,
    parameter logic [AW-1:0]   VEC_BASE  = 32'hFFF0_0000,
    parameter int              VEC_SHIFT = 8
) (
    input  logic [CLS_W-1:0] cls,
    output logic [AW-1:0]    vec
);

    generate
        if (VEC_SHIFT >= AW) begin : g_flat
            // Stride beyond the address width: every class lands on the base.
            logic unused_cls;
            assign unused_cls = ^cls;
            assign vec        = VEC_BASE;
        end else begin : g_stride
            localparam int SH = VEC_SHIFT;
            logic [AW-1:0] offs;
            assign offs = AW'(cls) << SH;
            // Sum truncated to AW bits: the carry out is discarded.
            assign vec  = VEC_BASE + offs;
        end
    endgenerate

endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
    import exc_pkg::*;
#(
    parameter int            AW       = 32,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          take_sync,
    input  logic [AW-1:0] head_pc,
    input  logic [AW-1:0] vec,
    input  logic          ret_go,
    input  logic          retire,
    input  logic          fpm_wr,
    input  logic [1:0]    fpm_val,
    output logic [AW-1:0] save0,
    output msr_t          save1,
    output msr_t          msr,
    output logic [AW-1:0] redir_q
);

    localparam logic [AW-1:0] STEP = AW'(4);

    logic [AW-1:0] next_seq;
    msr_t          msr_rst;

    assign msr_rst = '{fpm: FPM_OFF, ee: 1'b1, sup: 1'b0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            save0    <= '0;
            save1    <= '0;
            msr      <= msr_rst;
            redir_q  <= '0;
            next_seq <= RESET_PC;
        end else if (take) begin
            save0    <= take_sync ? head_pc : next_seq;
            save1    <= msr;
            msr.sup  <= 1'b1;
            msr.ee   <= 1'b0;
            redir_q  <= vec;
            next_seq <= vec;
        end else if (ret_go) begin
            msr      <= save1;
            redir_q  <= save0;
            next_seq <= save0;
        end else begin
            if (retire) begin
                next_seq <= head_pc + STEP;
            end
            if (fpm_wr) begin
                msr.fpm <= fpm_fold(fpm_val);
            end
        end
    end

endmodule

// File: rtl/exc_retire_ctrl.sv
module exc_retire_ctrl
    import exc_pkg::*;
#(
    parameter int            AW        = 32,
    parameter int            CLS_W     = 3,
    parameter logic [AW-1:0] VEC_BASE  = 32'hFFF0_0000,
    parameter int            VEC_SHIFT = 8,
    parameter logic [AW-1:0] RESET_PC  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_valid,
    input  logic             head_done,
    input  logic             head_exc,
    input  logic [CLS_W-1:0] head_cls,
    input  logic [AW-1:0]    head_pc,
    input  logic             rob_empty,
    input  logic             irq,
    input  logic             sreset,
    input  logic             mcheck,
    input  logic             rfi,
    input  logic             fpm_wr,
    input  logic [1:0]       fpm_val,
    output logic             retire,
    output logic             flush,
    output logic             hold_dispatch,
    output logic             redir_valid,
    output logic [AW-1:0]    redir_pc,
    output logic [AW-1:0]    save0,
    output logic [3:0]       save1,
    output logic             msr_sup,
    output logic             msr_ee,
    output logic [1:0]       fp_mode
);

    exc_state_t       st;
    logic             take;
    logic             take_sync;
    logic [CLS_W-1:0] take_cls;
    logic             ret_go;
    logic [AW-1:0]    vec;
    logic [AW-1:0]    redir_q;
    msr_t             msr;
    msr_t             save1_s;

    exc_fsm #(.CLS_W(CLS_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .head_valid    (head_valid),
        .head_done     (head_done),
        .head_exc      (head_exc),
        .head_cls      (head_cls),
        .rob_empty     (rob_empty),
        .irq           (irq),
        .irq_en        (msr.ee),
        .sreset        (sreset),
        .mcheck        (mcheck),
        .rfi           (rfi),
        .state_q       (st),
        .take          (take),
        .take_sync     (take_sync),
        .take_cls      (take_cls),
        .ret_go        (ret_go),
        .retire        (retire),
        .flush         (flush),
        .redir_valid   (redir_valid),
        .hold_dispatch (hold_dispatch)
    );

    exc_vector #(
        .AW        (AW),
        .CLS_W     (CLS_W),
        .VEC_BASE  (VEC_BASE),
        .VEC_SHIFT (VEC_SHIFT)
    ) u_vec (
        .cls (take_cls),
        .vec (vec)
    );

    exc_state_regs #(
        .AW       (AW),
        .RESET_PC (RESET_PC)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .take_sync (take_sync),
        .head_pc   (head_pc),
        .vec       (vec),
        .ret_go    (ret_go),
        .retire    (retire),
        .fpm_wr    (fpm_wr),
        .fpm_val   (fpm_val),
        .save0     (save0),
        .save1     (save1_s),
        .msr       (msr),
        .redir_q   (redir_q)
    );

    assign redir_pc = redir_q;
    assign save1    = save1_s;
    assign msr_sup  = msr.sup;
    assign msr_ee   = msr.ee;
    assign fp_mode  = msr.fpm;

endmodule

// File: rtl/exc_retire_chk.sv
module exc_retire_chk
    import exc_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input exc_state_t    st,
    input logic          head_valid,
    input logic          head_done,
    input logic          head_exc,
    input logic          sreset,
    input logic          mcheck,
    input logic          rfi,
    input logic          retire,
    input logic          flush,
    input logic          hold_dispatch,
    input logic [AW-1:0] redir_pc,
    input logic [AW-1:0] save0,
    input logic          msr_sup,
    input logic          msr_ee,
    input logic [1:0]    fp_mode
);

    p_retire_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> (head_valid && head_done && !head_exc));

    p_drain_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hold_dispatch |-> msr_ee);

    p_entry_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ENTER) |-> (msr_sup && !msr_ee));

    p_flush_no_retire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !retire);

    p_flush_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !sreset && !mcheck) |=> !flush);

    p_handler_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_HANDLER) && head_valid && head_done && head_exc
         && !rfi && !sreset && !mcheck) |=> (st == ST_HANDLER));

    p_return_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RETURN) |-> (redir_pc == save0));

    p_fpm_folded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fp_mode != FPM_IMP_REC);

    p_catastrophic_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sreset || mcheck) |=> (st == ST_ENTER));

endmodule

bind exc_retire_ctrl exc_retire_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .st            (st),
    .head_valid    (head_valid),
    .head_done     (head_done),
    .head_exc      (head_exc),
    .sreset        (sreset),
    .mcheck        (mcheck),
    .rfi           (rfi),
    .retire        (retire),
    .flush         (flush),
    .hold_dispatch (hold_dispatch),
    .redir_pc      (redir_pc),
    .save0         (save0),
    .msr_sup       (msr_sup),
    .msr_ee        (msr_ee),
    .fp_mode       (fp_mode)
);

// File: tb/sim_exc_retire_ctrl.sv
`timescale 1ns/1ps
module sim_exc_retire_ctrl;

    localparam logic [31:0] VBASE = 32'hFFFF_FC00;
    localparam int          WDOG  = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        head_valid = 0, head_done = 0, head_exc = 0;
    logic [2:0]  head_cls = 0;
    logic [31:0] head_pc = 0;
    logic        rob_empty = 0, irq = 0, sreset = 0, mcheck = 0, rfi = 0;
    logic        fpm_wr = 0;
    logic [1:0]  fpm_val = 0;
    logic        retire, flush, hold_dispatch, redir_valid;
    logic [31:0] redir_pc, save0;
    logic [3:0]  save1;
    logic        msr_sup, msr_ee;
    logic [1:0]  fp_mode;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    done = 0;
    string scen = "R11";

    // Behavioural model: 0 run, 1 drain, 2 enter, 3 handler, 4 return
    int          ms = 0;
    bit          m_sup = 0, m_ee = 1;
    bit [1:0]    m_fpm = 0;
    bit [31:0]   m_s0 = 0, m_next = 0, m_rd = 0;
    bit [3:0]    m_s1 = 0;

    always #5 clk = ~clk;

    exc_retire_ctrl #(.VEC_BASE(VBASE)) u0 (
        .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .head_done(head_done),
        .head_exc(head_exc), .head_cls(head_cls), .head_pc(head_pc),
        .rob_empty(rob_empty), .irq(irq), .sreset(sreset), .mcheck(mcheck),
        .rfi(rfi), .fpm_wr(fpm_wr), .fpm_val(fpm_val), .retire(retire),
        .flush(flush), .hold_dispatch(hold_dispatch), .redir_valid(redir_valid),
        .redir_pc(redir_pc), .save0(save0), .save1(save1), .msr_sup(msr_sup),
        .msr_ee(msr_ee), .fp_mode(fp_mode)
    );

    task automatic chk(input string what, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s (scenario %s) t=%0t got %h exp %h", req, what, scen,
                     $time, got, exp);
        end
    endtask

    function automatic bit [31:0] vec_of(input int cls);
        return VBASE + (32'(cls) << 8);
    endfunction

    always @(negedge clk) begin
        bit        e_ret, cat, bad, take, tsync, ret;
        int        tcls, nms;
        if (!done) begin
            e_ret = (ms == 0 || ms == 1 || (ms == 3 && !rfi)) && head_valid && head_done
                    && !head_exc && !(sreset || mcheck);
            chk("retire", "R1", 32'(retire), 32'(e_ret));
            chk("flush", "R6", 32'(flush), 32'(ms == 2 || ms == 4));
            chk("redir_valid", "R6", 32'(redir_valid), 32'(ms == 2 || ms == 4));
            if (ms == 2) chk("redir_pc vector", "R6", redir_pc, m_rd);
            if (ms == 4) chk("redir_pc return", "R8", redir_pc, m_rd);
            chk("hold_dispatch", "R3", 32'(hold_dispatch), 32'(ms == 1));
            chk("save0", "R4", save0, m_s0);
            chk("save1", "R5", 32'(save1), 32'(m_s1));
            chk("msr_sup", "R5", 32'(msr_sup), 32'(m_sup));
            chk("msr_ee", "R5", 32'(msr_ee), 32'(m_ee));
            chk("fp_mode", "R9", 32'(fp_mode), 32'(m_fpm));
            if (!rst_n) begin
                ms = 0; m_sup = 0; m_ee = 1; m_fpm = 0;
                m_s0 = 0; m_s1 = 0; m_next = 0; m_rd = 0;
            end else begin
                cat = sreset || mcheck;
                bad = head_valid && head_done && head_exc;
                take = 0; tsync = 0; ret = 0; tcls = 0; nms = ms;
                if (cat) begin
                    take = 1; tcls = sreset ? 1 : 2;
                end else begin
                    case (ms)
                        0: if (bad) begin take = 1; tsync = 1; tcls = int'(head_cls); end
                           else if (irq && m_ee) nms = 1;
                        1: if (bad) begin take = 1; tsync = 1; tcls = int'(head_cls); end
                           else if (!(irq && m_ee)) nms = 0;
                           else if (rob_empty) begin take = 1; tcls = 5; end
                        2: nms = 3;
                        3: if (rfi) begin ret = 1; nms = 4; end
                        default: nms = 0;
                    endcase
                end
                if (take) begin
                    m_s0 = tsync ? head_pc : m_next;
                    m_s1 = {m_fpm, m_ee, m_sup};
                    m_sup = 1; m_ee = 0;
                    m_rd = vec_of(tcls); m_next = m_rd;
                    nms = 2;
                end else if (ret) begin
                    {m_fpm, m_ee, m_sup} = m_s1;
                    m_rd = m_s0; m_next = m_s0;
                end else begin
                    if (e_ret) m_next = head_pc + 32'd4;
                    if (fpm_wr) m_fpm = (fpm_val == 2'b10) ? 2'b11 : fpm_val;
                end
                ms = nms;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clr();
        head_valid = 0; head_done = 0; head_exc = 0; head_cls = 0;
        rob_empty = 0; irq = 0; sreset = 0; mcheck = 0; rfi = 0; fpm_wr = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WDOG && !done) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    initial begin
        scen = "R11"; tick(3); rst_n = 1;
        // R1: in-order retirement, not-done head blocks
        scen = "R1";
        head_valid = 1; head_done = 0; head_pc = 32'h100; tick(2);
        head_done = 1; tick(1);
        head_pc = 32'h104; tick(1);
        // R2: synchronous exception at head
        scen = "R2";
        head_pc = 32'h108; head_exc = 1; head_cls = 3; tick(1);
        clr(); tick(2);
        // R7: handler retires, faulting head stalls, irq masked
        scen = "R7";
        head_valid = 1; head_done = 1; head_pc = 32'hFFFF_FF00; tick(1);
        head_pc = 32'hFFFF_FF04; head_exc = 1; head_cls = 6; tick(3);
        irq = 1; tick(2);
        // R8: return from exception
        scen = "R8";
        rfi = 1; tick(1);
        clr(); tick(2);
        rfi = 1; tick(1); clr(); tick(1);
        // R3: interrupt waits for drain
        scen = "R3";
        irq = 1; head_valid = 1; head_done = 0; head_pc = 32'h108; tick(2);
        head_done = 1; tick(1);
        head_valid = 0; head_done = 0; rob_empty = 1; tick(1);
        irq = 0; rob_empty = 0; tick(2);
        rfi = 1; tick(1); clr(); tick(2);
        irq = 1; tick(2);
        irq = 0; tick(2);
        // R4: next sequential address wraps
        scen = "R4";
        head_valid = 1; head_done = 1; head_pc = 32'hFFFF_FFFC; tick(1);
        clr(); irq = 1; rob_empty = 1; tick(3);
        clr(); tick(1); rfi = 1; tick(1); clr(); tick(2);
        // R9: floating-point mode writes
        scen = "R9";
        fpm_wr = 1; fpm_val = 2'b01; tick(1);
        fpm_val = 2'b10; tick(1);
        fpm_val = 2'b11; tick(1);
        fpm_val = 2'b00; tick(1);
        fpm_val = 2'b10; tick(1);
        fpm_val = 2'b01; head_valid = 1; head_done = 1; head_exc = 1; head_cls = 4;
        head_pc = 32'h200; tick(1);
        clr(); tick(2); rfi = 1; tick(1); clr(); tick(2);
        // R10: catastrophic requests in handler and entry
        scen = "R10";
        head_valid = 1; head_done = 1; head_exc = 1; head_cls = 3; head_pc = 32'h300; tick(1);
        clr(); tick(2);
        mcheck = 1; tick(1);
        sreset = 1; mcheck = 1; tick(1);
        clr(); tick(2);
        rfi = 1; tick(1); clr(); tick(2);
        scen = "R3";
        irq = 1; rob_empty = 1; tick(3);
        clr();
        scen = "R10";
        sreset = 1; tick(1); clr(); tick(2);
        rfi = 1; tick(1); clr(); tick(3);
        finish_run();
    end

endmodule